// File: doc/BRIEF.md
# Forwarded Read-Modify-Write Counter Memory

This block holds one counter per address in a two-port RAM and updates one entry every clock. Each accepted operation names an address; the block fetches the stored value, adds a fixed step, sends the result out, and keeps the result for later storage. The block never stalls, even when the same address comes back in consecutive cycles.

The RAM read takes one cycle, so the block does not write a new result back at once. The newest result waits in a holding register. It is stored during the next operation, on the write port, while that operation reads on the other port. A read that targets the held address, or the address being stored in that same cycle, gets its value from the registers and not from the RAM.

A synchronous clear makes every entry read as zero from the next operation on. It also drops any operation that is in flight.

Top module: `rmw_fwd_mem`

## Requirements
- R1: While reset is asserted and after it is released, out_vld is 0 and out_val is 0. Every address reads as zero until it is first updated.
- R2: Each operation sampled with in_vld=1 and clr=0 gives exactly one result, with out_vld=1 two clock edges after the edge that sampled it, unless clr is sampled in between. out_addr carries the operation's address. No other cycle has out_vld=1.
- R3: out_val is the value stored for the address plus STEP, modulo 2^DATA_W. The first access to an address after reset or clear returns STEP.
- R4: Operations to the same address on consecutive cycles are all accepted. They return STEP, 2*STEP, 3*STEP and so on, with no stall.
- R5: An address reused two operations later (pattern A,B,A) returns a value that includes the earlier update to A.
- R6: Addresses reused after a longer spacing, and traffic mixing many addresses, return their running totals.
- R7: clr=1 makes all entries read as zero. An in_vld sampled together with clr is ignored, and out_vld is 0 in the cycle after clr is sampled.
- R8: A counter that passes 2^DATA_W-1 wraps through zero and keeps counting.
- R9: Idle cycles (in_vld=0) change nothing. The held result is still forwarded to a later operation on its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all entries; drops in-flight work |
| in_vld | input | 1 | Operation request this cycle |
| in_addr | input | ADDR_W | Entry to update |
| out_vld | output | 1 | Result valid |
| out_addr | output | ADDR_W | Entry the result belongs to |
| out_val | output | DATA_W | Updated value of that entry |

## Verification
The bench targets the three hazard distances.

- **Distance one** (the same address in back-to-back cycles): a design without the holding-register bypass returns the same count twice.
- **Distance two** (A,B,A): this case hits the cycle where the deferred store and the new read collide on the RAM. A design that forwards only from the holding register returns the value from before the update.
- **Idle gaps before reuse**: a design that drops or loses the pending store loses an increment.

Clear is driven together with a request, to catch a design that lets the request through or keeps old entries. A long run on one address checks the wrap past the top of the counter range.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   // Where the pre-update value of an operation is taken from
   typedef enum logic [1:0] {
      SRC_RAM  = 2'd0,
      SRC_HOLD = 2'd1,
      SRC_WB   = 2'd2,
      SRC_ZERO = 2'd3
   } rmw_src_e;

   localparam int unsigned RMW_MAX_ADDR_W = 12;
   localparam int unsigned RMW_MIN_DATA_W = 2;

endpackage

// File: rtl/rmw_dpram.sv
// One write port, one read port, registered read data (one cycle latency).
module rmw_dpram #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/rmw_live_map.sv
// Per-entry "has been written since clear" flags; lookup is registered to
// line up with the RAM read data.
module rmw_live_map #(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          set_en,
   input  logic [AW-1:0] set_addr,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_live
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DEPTH-1:0] live;

   for (genvar i = 0; i < DEPTH; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            live[i] <= 1'b0;
         else if (clr)
            live[i] <= 1'b0;
         else if (set_en && (set_addr == AW'(i)))
            live[i] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_live <= 1'b0;
      else if (rd_en)
         rd_live <= live[rd_addr];
   end
endmodule

// File: rtl/rmw_fwd_select.sv
// Picks the freshest pre-update value and applies the step.
module rmw_fwd_select
   import rmw_pkg::*;
#(
   parameter int unsigned AW   = 4,
   parameter int unsigned DW   = 16,
   parameter int unsigned STEP = 1
) (
   input  logic [AW-1:0] op_addr,
   input  logic [DW-1:0] ram_q,
   input  logic          ram_live,
   input  logic          hold_vld,
   input  logic [AW-1:0] hold_addr,
   input  logic [DW-1:0] hold_val,
   input  logic          wb_vld,
   input  logic [AW-1:0] wb_addr,
   input  logic [DW-1:0] wb_val,
   output rmw_src_e      src,
   output logic [DW-1:0] new_val
);
   logic [DW-1:0] base;

   always_comb begin
      if (hold_vld && (hold_addr == op_addr))
         src = SRC_HOLD;
      else if (wb_vld && (wb_addr == op_addr))
         src = SRC_WB;
      else if (ram_live)
         src = SRC_RAM;
      else
         src = SRC_ZERO;
   end

   always_comb begin
      unique case (src)
         SRC_HOLD: base = hold_val;
         SRC_WB:   base = wb_val;
         SRC_RAM:  base = ram_q;
         default:  base = '0;
      endcase
   end

   if (STEP == 1) begin : g_inc
      assign new_val = base + DW'(1);
   end else begin : g_add
      assign new_val = base + DW'(STEP);
   end
endmodule

// File: rtl/rmw_fwd_mem.sv
module rmw_fwd_mem
   import rmw_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned STEP   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_vld,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_vld,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_val
);
   if (ADDR_W < 1 || ADDR_W > RMW_MAX_ADDR_W) begin : g_bad_aw
      $error("rmw_fwd_mem: ADDR_W out of range");
   end
   if (DATA_W < RMW_MIN_DATA_W) begin : g_bad_dw
      $error("rmw_fwd_mem: DATA_W too small");
   end
   if (STEP < 1 || STEP >= (64'd1 << DATA_W)) begin : g_bad_step
      $error("rmw_fwd_mem: STEP must be in 1 .. 2**DATA_W-1");
   end

   // stage 1: operation whose RAM read is in flight
   logic              s1_vld;
   logic [ADDR_W-1:0] s1_addr;

   // holding register: newest result, not yet stored
   logic              hold_vld;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_val;

   // last stored entry: written on the same edge as the current read
   logic              wb_vld;
   logic [ADDR_W-1:0] wb_addr;
   logic [DATA_W-1:0] wb_val;

   logic              rd_en;
   logic              commit;
   logic [DATA_W-1:0] ram_q;
   logic              ram_live;
   rmw_src_e          src;
   logic [DATA_W-1:0] new_val;

   assign rd_en  = in_vld && !clr;
   assign commit = s1_vld && hold_vld && !clr;

   rmw_dpram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (commit),
      .waddr (hold_addr),
      .wdata (hold_val),
      .re    (rd_en),
      .raddr (in_addr),
      .rdata (ram_q)
   );

   rmw_live_map #(.AW(ADDR_W)) u_live (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .set_en   (commit),
      .set_addr (hold_addr),
      .rd_en    (rd_en),
      .rd_addr  (in_addr),
      .rd_live  (ram_live)
   );

   rmw_fwd_select #(.AW(ADDR_W), .DW(DATA_W), .STEP(STEP)) u_sel (
      .op_addr   (s1_addr),
      .ram_q     (ram_q),
      .ram_live  (ram_live),
      .hold_vld  (hold_vld),
      .hold_addr (hold_addr),
      .hold_val  (hold_val),
      .wb_vld    (wb_vld),
      .wb_addr   (wb_addr),
      .wb_val    (wb_val),
      .src       (src),
      .new_val   (new_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_addr <= '0;
      end else begin
         s1_vld <= rd_en;
         if (rd_en) s1_addr <= in_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_addr <= '0;
         hold_val  <= '0;
      end else if (clr) begin
         hold_vld  <= 1'b0;
      end else if (s1_vld) begin
         hold_vld  <= 1'b1;
         hold_addr <= s1_addr;
         hold_val  <= new_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_vld  <= 1'b0;
         wb_addr <= '0;
         wb_val  <= '0;
      end else if (clr) begin
         wb_vld  <= 1'b0;
      end else if (commit) begin
         wb_vld  <= 1'b1;
         wb_addr <= hold_addr;
         wb_val  <= hold_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_addr <= '0;
         out_val  <= '0;
      end else begin
         out_vld <= s1_vld && !clr;
         if (s1_vld && !clr) begin
            out_addr <= s1_addr;
            out_val  <= new_val;
         end
      end
   end
endmodule

// File: rtl/rmw_fwd_mem_chk.sv
module rmw_fwd_mem_chk #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned STEP   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              in_vld,
   input logic [ADDR_W-1:0] in_addr,
   input logic              out_vld,
   input logic [ADDR_W-1:0] out_addr,
   input logic [DATA_W-1:0] out_val
);
   // R2: an accepted request surfaces two edges later unless cleared
   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_vld && !clr, 2) && !$past(clr)) |-> out_vld);

   // R2: no result without a matching accepted request
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ($past(in_vld, 2) && !$past(clr, 2) && !$past(clr)));

   // R2: result carries the requested address
   a_r2_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_addr == $past(in_addr, 2)));

   // R4: consecutive results on one address differ by exactly STEP
   a_r4_same_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && $past(out_vld) && (out_addr == $past(out_addr)))
         |-> (out_val == DATA_W'($past(out_val) + STEP)));

   // R7: the cycle after a clear carries no result
   a_r7_clr_flush: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> !out_vld);
endmodule

bind rmw_fwd_mem rmw_fwd_mem_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .STEP   (STEP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .in_vld   (in_vld),
   .in_addr  (in_addr),
   .out_vld  (out_vld),
   .out_addr (out_addr),
   .out_val  (out_val)
);

// File: tb/sim_rmw_fwd_mem.sv
`timescale 1ns/1ps
module sim_rmw_fwd_mem;
   localparam int unsigned AW    = 4;
   localparam int unsigned DW    = 8;
   localparam int unsigned STEP  = 1;
   localparam int unsigned DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          in_vld = 1'b0;
   logic [AW-1:0] in_addr = '0;
   logic          out_vld;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_val;

   int checks = 0;
   int errors = 0;

   // 50 MHz
   always #10 clk = ~clk;

   rmw_fwd_mem #(.ADDR_W(AW), .DATA_W(DW), .STEP(STEP)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_vld   (in_vld),
      .in_addr  (in_addr),
      .out_vld  (out_vld),
      .out_addr (out_addr),
      .out_val  (out_val)
   );

   // reference model
   logic [DW-1:0] model [DEPTH];
   logic          nx_vld = 1'b0;
   logic [AW-1:0] nx_addr = '0;
   logic [DW-1:0] nx_val = '0;
   logic          hd_vld = 1'b0;
   logic [AW-1:0] hd_addr = '0;
   logic [DW-1:0] hd_val = '0;
   logic          mon_en = 1'b0;
   string         cur_req = "R1";

   // Output monitor: samples 5 ns after each rising edge
   always @(posedge clk) begin
      #5;
      if (mon_en) begin
         checks++;
         if (out_vld !== hd_vld) begin
            errors++;
            $display("FAIL R2 (%s) out_vld act=%0b exp=%0b t=%0t", cur_req, out_vld, hd_vld, $time);
         end else if (hd_vld) begin
            if (out_addr !== hd_addr) begin
               errors++;
               $display("FAIL R2 (%s) out_addr act=%0d exp=%0d", cur_req, out_addr, hd_addr);
            end
            if (out_val !== hd_val) begin
               errors++;
               $display("FAIL %s out_val addr=%0d act=%0d exp=%0d", cur_req, hd_addr, out_val, hd_val);
            end
         end
      end
      hd_vld  = nx_vld;
      hd_addr = nx_addr;
      hd_val  = nx_val;
   end

   task automatic op(input logic [AW-1:0] a);
      @(negedge clk);
      clr     = 1'b0;
      in_vld  = 1'b1;
      in_addr = a;
      model[a] = DW'(model[a] + STEP);
      nx_vld  = 1'b1;
      nx_addr = a;
      nx_val  = model[a];
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         clr    = 1'b0;
         in_vld = 1'b0;
         nx_vld = 1'b0;
      end
   endtask

   task automatic do_clear(input logic with_req, input logic [AW-1:0] a);
      idle(2);
      @(negedge clk);
      clr     = 1'b1;
      in_vld  = with_req;
      in_addr = a;
      nx_vld  = 1'b0;
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      idle(1);
   endtask

   task automatic t_reset;
      cur_req = "R1";
      checks++;
      if (out_vld !== 1'b0 || out_val !== '0) begin
         errors++;
         $display("FAIL R1 reset out_vld=%0b out_val=%0d exp 0/0", out_vld, out_val);
      end
   endtask

   task automatic t_first_touch;
      cur_req = "R3";
      for (int i = 0; i < DEPTH; i++) op(AW'(i));
      idle(3);
   endtask

   task automatic t_burst_same;
      cur_req = "R4";
      for (int i = 0; i < 20; i++) op(AW'(5));
      idle(3);
   endtask

   task automatic t_distance_two;
      cur_req = "R5";
      for (int i = 0; i < 8; i++) begin
         op(AW'(2));
         op(AW'(9));
      end
      op(AW'(1)); op(AW'(4)); op(AW'(1)); op(AW'(4)); op(AW'(4)); op(AW'(1));
      idle(3);
   endtask

   task automatic t_idle_gap;
      cur_req = "R9";
      op(AW'(7));
      idle(1);
      op(AW'(7));
      idle(4);
      op(AW'(7));
      op(AW'(3));
      idle(2);
      op(AW'(7));
      idle(3);
   endtask

   task automatic t_clear;
      cur_req = "R7";
      do_clear(1'b1, AW'(5));
      op(AW'(5));
      op(AW'(2));
      op(AW'(7));
      op(AW'(5));
      idle(3);
      checks++;
      if (model[5] !== DW'(2 * STEP)) begin
         errors++;
         $display("FAIL R7 model after clear act=%0d exp=%0d", model[5], 2 * STEP);
      end
   endtask

   task automatic t_wrap;
      cur_req = "R8";
      do_clear(1'b0, '0);
      for (int i = 0; i < (1 << DW) + 4; i++) op(AW'(3));
      idle(3);
   endtask

   task automatic t_mixed;
      logic [15:0] lfsr;
      cur_req = "R6";
      lfsr = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[7:6] == 2'b00) idle(1);
         else op(AW'(lfsr[AW-1:0]));
      end
      idle(3);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      mon_en = 1'b1;
      t_first_touch;
      t_burst_same;
      t_distance_two;
      t_idle_gap;
      t_clear;
      t_wrap;
      t_mixed;
      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule